// File: doc/BRIEF.md
# Backoff Spin-Lock Acquire Controller

This block acquires one shared lock word in memory for a single requester. It uses test-and-test-and-set. It polls the word with plain reads while the word is held. When a read finds the word free, it waits out a backoff delay and then issues an atomic test-and-set. If that test-and-set loses the race, the controller counts a collision, grows its delay and goes back to polling. If it wins, the controller raises `granted` and keeps it high until a release strobe arrives. The release writes the word clear.

In the dynamic mode the delay starts at a small initial value, which defaults to zero. An uncontended acquire therefore costs one read and one test-and-set, with no wait between them. Each collision doubles the delay, and a zero delay grows to one. The delay saturates at a parameter ceiling. A win returns the delay to its initial value. In the static mode each requester is given a fixed wait slot by a parameter, and collisions do not change it.

Top module: `spinlock_backoff_ctrl`

## Requirements
- R1: After reset, `granted` is low and `mem_req_valid` is low until `acq_req` is seen. At most one memory transaction is outstanding at a time.
- R2: While read responses return BUSY (`mem_rsp_busy`=1), the controller issues only reads (`mem_req_op`=2'b00) and never a test-and-set.
- R3: With a zero delay, a read response returning CLEAR is followed by a test-and-set request (`mem_req_op`=2'b01) in the very next cycle.
- R4: With a current delay d, the test-and-set request first appears d+1 cycles after the cycle of the CLEAR read response.
- R5: In the dynamic mode, a test-and-set response of BUSY is a collision. The controller then returns to read polling, and the delay becomes 1 if it was 0, or doubles otherwise, limited to `DLY_MAX`.
- R6: A test-and-set response of CLEAR raises `granted` on the next cycle and restores the delay to `DLY_INIT`.
- R7: An `rel_req` pulse while granted drops `granted` on the next cycle and issues one write-clear request (`mem_req_op`=2'b10). After its response the controller is idle again.
- R8: In the static mode (`STATIC_MODE`=1), every test-and-set waits `STATIC_SLOT` cycles after the CLEAR read, whatever collisions came before.
- R9: A request whose `mem_req_ready` is low stays valid with an unchanged opcode until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acq_req | input | 1 | Start an acquire (sampled when idle) |
| rel_req | input | 1 | Release strobe (sampled while granted) |
| granted | output | 1 | Lock is held by this requester |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_op | output | 2 | 00 read, 01 test-and-set, 10 write clear |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_busy | input | 1 | Returned lock value: 1 BUSY, 0 CLEAR |

## Verification
Acquisition is tried on a free lock, on a lock held by another owner for many polls, and on a lock that a competitor steals at each test-and-set over a run of attempts. The free lock shows the zero-latency path. The held lock shows that polling never turns into test-and-sets. The stolen-lock run separates correct doubling, the zero-to-one step and saturation by the gap measured before each test-and-set. A stalled memory port and a static-slot instance show the request hold rule and that the fixed slot ignores collisions.

// File: rtl/spl_pkg.sv
package spl_pkg;
   typedef enum logic [1:0] {
      SPL_OP_READ  = 2'b00,
      SPL_OP_TAS   = 2'b01,
      SPL_OP_CLEAR = 2'b10
   } spl_op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_REQ,
      ST_RD_RSP,
      ST_WAIT,
      ST_TAS_REQ,
      ST_TAS_RSP,
      ST_HELD,
      ST_CLR_REQ,
      ST_CLR_RSP
   } spl_state_e;
endpackage

// File: rtl/spl_backoff_reg.sv
module spl_backoff_reg #(
   parameter int DLY_W       = 8,
   parameter int DLY_INIT    = 0,
   parameter int DLY_MAX     = 64,
   parameter bit STATIC_MODE = 1'b0,
   parameter int STATIC_SLOT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             collide_i,
   input  logic             win_i,
   output logic [DLY_W-1:0] dly_o
);
   localparam logic [DLY_W-1:0] INIT_V = DLY_INIT[DLY_W-1:0];
   localparam logic [DLY_W-1:0] MAX_V  = DLY_MAX[DLY_W-1:0];
   localparam logic [DLY_W-1:0] SLOT_V = STATIC_SLOT[DLY_W-1:0];

   logic [DLY_W-1:0] dly_q;

   generate
      if (STATIC_MODE) begin : g_static
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 dly_q <= SLOT_V;
            else if (collide_i || win_i) dly_q <= SLOT_V;
         end
      end else begin : g_dynamic
         logic [DLY_W:0]   dbl;
         logic [DLY_W-1:0] grown;
         always_comb begin
            dbl = {dly_q, 1'b0};
            if (dly_q == '0)                   grown = {{(DLY_W-1){1'b0}}, 1'b1};
            else if (dbl > {1'b0, MAX_V})      grown = MAX_V;
            else                               grown = dbl[DLY_W-1:0];
            if (grown > MAX_V)                 grown = MAX_V;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         dly_q <= INIT_V;
            else if (win_i)     dly_q <= INIT_V;
            else if (collide_i) dly_q <= grown;
         end
      end
   endgenerate

   assign dly_o = dly_q;
endmodule

// File: rtl/spl_wait_timer.sv
module spl_wait_timer #(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [DLY_W-1:0] load_val_i,
   input  logic             run_i,
   output logic             last_o
);
   localparam logic [DLY_W-1:0] ONE = {{(DLY_W-1){1'b0}}, 1'b1};

   logic [DLY_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (load_i)                 cnt_q <= load_val_i;
      else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - ONE;
   end

   assign last_o = (cnt_q <= ONE);
endmodule

// File: rtl/spinlock_backoff_ctrl.sv
module spinlock_backoff_ctrl
   import spl_pkg::*;
#(
   parameter int DLY_W       = 8,
   parameter int DLY_INIT    = 0,
   parameter int DLY_MAX     = 64,
   parameter bit STATIC_MODE = 1'b0,
   parameter int STATIC_SLOT = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acq_req,
   input  logic       rel_req,
   output logic       granted,
   output logic       mem_req_valid,
   input  logic       mem_req_ready,
   output logic [1:0] mem_req_op,
   input  logic       mem_rsp_valid,
   input  logic       mem_rsp_busy
);
   localparam int DLY_LIMIT = (1 << DLY_W) - 1;

   generate
      if (DLY_W < 2 || DLY_W > 24) begin : g_bad_width
         $error("spinlock_backoff_ctrl: DLY_W out of range");
      end
      if (DLY_MAX < 1 || DLY_MAX > DLY_LIMIT) begin : g_bad_max
         $error("spinlock_backoff_ctrl: DLY_MAX does not fit DLY_W");
      end
      if (DLY_INIT < 0 || DLY_INIT > DLY_MAX) begin : g_bad_init
         $error("spinlock_backoff_ctrl: DLY_INIT above DLY_MAX");
      end
      if (STATIC_SLOT < 0 || STATIC_SLOT > DLY_LIMIT) begin : g_bad_slot
         $error("spinlock_backoff_ctrl: STATIC_SLOT does not fit DLY_W");
      end
   endgenerate

   spl_state_e       state_q, state_d;
   logic [DLY_W-1:0] dly_q;
   logic             collide, win;
   logic             tmr_load, tmr_run, tmr_last;

   assign collide  = (state_q == ST_TAS_RSP) && mem_rsp_valid &&  mem_rsp_busy;
   assign win      = (state_q == ST_TAS_RSP) && mem_rsp_valid && !mem_rsp_busy;
   assign tmr_load = (state_q == ST_RD_RSP)  && mem_rsp_valid && !mem_rsp_busy;
   assign tmr_run  = (state_q == ST_WAIT);

   spl_backoff_reg #(
      .DLY_W      (DLY_W),
      .DLY_INIT   (DLY_INIT),
      .DLY_MAX    (DLY_MAX),
      .STATIC_MODE(STATIC_MODE),
      .STATIC_SLOT(STATIC_SLOT)
   ) u_backoff (
      .clk      (clk),
      .rst_n    (rst_n),
      .collide_i(collide),
      .win_i    (win),
      .dly_o    (dly_q)
   );

   spl_wait_timer #(
      .DLY_W(DLY_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (tmr_load),
      .load_val_i(dly_q),
      .run_i     (tmr_run),
      .last_o    (tmr_last)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (acq_req)       state_d = ST_RD_REQ;
         ST_RD_REQ:  if (mem_req_ready) state_d = ST_RD_RSP;
         ST_RD_RSP:
            if (mem_rsp_valid) begin
               if (mem_rsp_busy)        state_d = ST_RD_REQ;
               else if (dly_q == '0)    state_d = ST_TAS_REQ;
               else                     state_d = ST_WAIT;
            end
         ST_WAIT:    if (tmr_last)      state_d = ST_TAS_REQ;
         ST_TAS_REQ: if (mem_req_ready) state_d = ST_TAS_RSP;
         ST_TAS_RSP:
            if (mem_rsp_valid)          state_d = mem_rsp_busy ? ST_RD_REQ : ST_HELD;
         ST_HELD:    if (rel_req)       state_d = ST_CLR_REQ;
         ST_CLR_REQ: if (mem_req_ready) state_d = ST_CLR_RSP;
         ST_CLR_RSP: if (mem_rsp_valid) state_d = ST_IDLE;
         default:                       state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      mem_req_valid = 1'b0;
      mem_req_op    = SPL_OP_READ;
      unique case (state_q)
         ST_RD_REQ:  begin mem_req_valid = 1'b1; mem_req_op = SPL_OP_READ;  end
         ST_TAS_REQ: begin mem_req_valid = 1'b1; mem_req_op = SPL_OP_TAS;   end
         ST_CLR_REQ: begin mem_req_valid = 1'b1; mem_req_op = SPL_OP_CLEAR; end
         default:    ;
      endcase
   end

   assign granted = (state_q == ST_HELD);
endmodule

// File: rtl/spl_backoff_chk.sv
module spl_backoff_chk #(
   parameter int DLY_W       = 8,
   parameter int DLY_MAX     = 64,
   parameter bit STATIC_MODE = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             granted,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [1:0]       mem_req_op,
   input logic             mem_rsp_valid,
   input logic             mem_rsp_busy,
   input logic [DLY_W-1:0] cur_dly
);
   logic       pend_q;
   logic [1:0] pend_op_q;
   logic       saw_clr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         pend_op_q <= 2'b00;
         saw_clr_q <= 1'b0;
      end else begin
         if (mem_req_valid && mem_req_ready) begin
            pend_q    <= 1'b1;
            pend_op_q <= mem_req_op;
            if (mem_req_op == 2'b01) saw_clr_q <= 1'b0;
         end else if (mem_rsp_valid) begin
            pend_q <= 1'b0;
         end
         if (mem_rsp_valid && pend_q && pend_op_q == 2'b00)
            saw_clr_q <= !mem_rsp_busy;
      end
   end

   a_r1_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !pend_q);

   a_r2_tas_after_clear_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_op == 2'b01) |-> saw_clr_q);

   a_r5_delay_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (STATIC_MODE || cur_dly <= DLY_W'(DLY_MAX)));

   a_r5_no_shrink_on_collision: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rsp_valid && pend_q && pend_op_q == 2'b01 && mem_rsp_busy)
      |=> (cur_dly >= $past(cur_dly) && !granted));

   a_r6_grant_from_tas_win: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(granted) |-> $past(mem_rsp_valid && pend_q && pend_op_q == 2'b01 && !mem_rsp_busy));

   a_r7_release_writes_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(granted) |-> (mem_req_valid && mem_req_op == 2'b10));

   a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_op)));
endmodule

bind spinlock_backoff_ctrl spl_backoff_chk #(
   .DLY_W      (DLY_W),
   .DLY_MAX    (DLY_MAX),
   .STATIC_MODE(STATIC_MODE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .granted      (granted),
   .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready),
   .mem_req_op   (mem_req_op),
   .mem_rsp_valid(mem_rsp_valid),
   .mem_rsp_busy (mem_rsp_busy),
   .cur_dly      (dly_q)
);

// File: tb/spinlock_backoff_ctrl_tb.sv
module spl_mem_model (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        stall,
   input  logic        other_hold,
   input  logic [15:0] steal_upto,
   input  logic        req_valid,
   input  logic [1:0]  req_op,
   output logic        req_ready,
   output logic        rsp_valid,
   output logic        rsp_busy,
   output logic [15:0] tas_cnt,
   output logic [15:0] rd_cnt,
   output logic [15:0] wr_cnt,
   output logic [15:0] last_gap
);
   logic        own_lock, pv, pacc, pend_rd;
   logic [15:0] cyc, clr_cyc;

   assign req_ready = !stall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_lock <= 1'b0; pv <= 1'b0; pacc <= 1'b0; pend_rd <= 1'b0;
         cyc <= '0; clr_cyc <= '0; rsp_valid <= 1'b0; rsp_busy <= 1'b0;
         tas_cnt <= '0; rd_cnt <= '0; wr_cnt <= '0; last_gap <= '0;
      end else begin
         cyc       <= cyc + 16'd1;
         rsp_valid <= 1'b0;
         pv        <= req_valid;
         pacc      <= req_valid && req_ready;
         if (rsp_valid && pend_rd && !rsp_busy) clr_cyc <= cyc;
         if (req_valid && req_op == 2'b01 && (!pv || pacc)) last_gap <= cyc - clr_cyc;
         if (req_valid && req_ready) begin
            rsp_valid <= 1'b1;
            pend_rd   <= (req_op == 2'b00);
            case (req_op)
               2'b00: begin
                  rsp_busy <= own_lock || other_hold;
                  rd_cnt   <= rd_cnt + 16'd1;
               end
               2'b01: begin
                  tas_cnt <= tas_cnt + 16'd1;
                  if (own_lock || other_hold || tas_cnt < steal_upto) rsp_busy <= 1'b1;
                  else begin rsp_busy <= 1'b0; own_lock <= 1'b1; end
               end
               default: begin
                  own_lock <= 1'b0;
                  rsp_busy <= 1'b0;
                  wr_cnt   <= wr_cnt + 16'd1;
               end
            endcase
         end
      end
   end
endmodule

module spinlock_backoff_ctrl_tb;
   localparam int DMAX = 4;
   localparam int SLOT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int checks = 0;
   int fails  = 0;

   // main (dynamic) instance
   logic        acq = 1'b0, rel = 1'b0, stall = 1'b0, other = 1'b0;
   logic [15:0] steal = '0;
   logic        granted, req_valid, req_ready, rsp_valid, rsp_busy;
   logic [1:0]  req_op;
   logic [15:0] tas_cnt, rd_cnt, wr_cnt, last_gap;

   // static-slot instance
   logic        acq_s = 1'b0, rel_s = 1'b0;
   logic [15:0] steal_s = '0;
   logic        granted_s, req_valid_s, req_ready_s, rsp_valid_s, rsp_busy_s;
   logic [1:0]  req_op_s;
   logic [15:0] tas_cnt_s, rd_cnt_s, wr_cnt_s, last_gap_s;

   spinlock_backoff_ctrl #(.DLY_W(6), .DLY_INIT(0), .DLY_MAX(DMAX), .STATIC_MODE(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .acq_req(acq), .rel_req(rel), .granted(granted),
      .mem_req_valid(req_valid), .mem_req_ready(req_ready), .mem_req_op(req_op),
      .mem_rsp_valid(rsp_valid), .mem_rsp_busy(rsp_busy));

   spl_mem_model u_mem (
      .clk(clk), .rst_n(rst_n), .stall(stall), .other_hold(other), .steal_upto(steal),
      .req_valid(req_valid), .req_op(req_op), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_busy(rsp_busy), .tas_cnt(tas_cnt), .rd_cnt(rd_cnt),
      .wr_cnt(wr_cnt), .last_gap(last_gap));

   spinlock_backoff_ctrl #(.DLY_W(6), .DLY_INIT(0), .DLY_MAX(DMAX), .STATIC_MODE(1'b1),
                           .STATIC_SLOT(SLOT)) u_dut_st (
      .clk(clk), .rst_n(rst_n), .acq_req(acq_s), .rel_req(rel_s), .granted(granted_s),
      .mem_req_valid(req_valid_s), .mem_req_ready(req_ready_s), .mem_req_op(req_op_s),
      .mem_rsp_valid(rsp_valid_s), .mem_rsp_busy(rsp_busy_s));

   spl_mem_model u_mem_st (
      .clk(clk), .rst_n(rst_n), .stall(1'b0), .other_hold(1'b0), .steal_upto(steal_s),
      .req_valid(req_valid_s), .req_op(req_op_s), .req_ready(req_ready_s),
      .rsp_valid(rsp_valid_s), .rsp_busy(rsp_busy_s), .tas_cnt(tas_cnt_s), .rd_cnt(rd_cnt_s),
      .wr_cnt(wr_cnt_s), .last_gap(last_gap_s));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_acq();
      @(negedge clk) acq = 1'b1;
      @(negedge clk) acq = 1'b0;
   endtask

   task automatic wait_grant(input string req);
      int n = 0;
      while (!granted && n < 200) begin @(negedge clk); n++; end
      check(granted, req, granted, 1);
   endtask

   task automatic do_release();
      int w0 = wr_cnt;
      @(negedge clk) rel = 1'b1;
      @(negedge clk) rel = 1'b0;
      check(!granted, "R7 granted drops", granted, 0);
      repeat (3) @(negedge clk);
      check(wr_cnt == w0 + 1, "R7 one write-clear", wr_cnt - w0, 1);
      check(!req_valid, "R7 idle after release", req_valid, 0);
   endtask

   task automatic t_reset();
      check(!granted && !req_valid, "R1 reset state", {granted, req_valid}, 0);
      repeat (3) @(negedge clk);
      check(!req_valid, "R1 no request without acq_req", req_valid, 0);
   endtask

   task automatic t_uncontended();
      int t0 = tas_cnt;
      pulse_acq();
      wait_grant("R6 uncontended grant");
      check(last_gap == 1, "R3 zero-delay tas gap", last_gap, 1);
      check(tas_cnt - t0 == 1, "R6 single tas", tas_cnt - t0, 1);
      do_release();
   endtask

   task automatic t_busy_poll();
      int t0 = tas_cnt;
      int r0 = rd_cnt;
      other = 1'b1;
      pulse_acq();
      repeat (30) @(negedge clk);
      check(tas_cnt == t0, "R2 no tas while busy", tas_cnt - t0, 0);
      check(rd_cnt - r0 >= 5, "R2 polling reads", rd_cnt - r0, 5);
      check(!granted, "R2 not granted while busy", granted, 0);
      other = 1'b0;
      wait_grant("R2 grant after free");
      check(last_gap == 1, "R4 delay unchanged by busy polls", last_gap, 1);
      do_release();
   endtask

   task automatic t_backoff();
      int d = 0;
      int n = 0;
      int t0;
      steal = tas_cnt + 16'd4;
      pulse_acq();
      for (int k = 0; k < 5; k++) begin
         t0 = tas_cnt;
         n  = 0;
         while (tas_cnt == t0 && n < 200) begin @(negedge clk); n++; end
         check(last_gap == d + 1, "R4 R5 backoff gap", last_gap, d + 1);
         d = (d == 0) ? 1 : ((2 * d > DMAX) ? DMAX : 2 * d);
      end
      wait_grant("R6 grant after collisions");
      do_release();
      pulse_acq();
      wait_grant("R6 reacquire");
      check(last_gap == 1, "R6 delay reset after win", last_gap, 1);
      do_release();
   endtask

   task automatic t_stall();
      stall = 1'b1;
      pulse_acq();
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         check(req_valid && req_op == 2'b00, "R9 read held under stall", {req_valid, req_op}, 4);
      end
      stall = 1'b0;
      wait_grant("R9 grant after stall");
      do_release();
   endtask

   task automatic t_static();
      int t0;
      int n;
      steal_s = tas_cnt_s + 16'd2;
      @(negedge clk) acq_s = 1'b1;
      @(negedge clk) acq_s = 1'b0;
      for (int k = 0; k < 3; k++) begin
         t0 = tas_cnt_s;
         n  = 0;
         while (tas_cnt_s == t0 && n < 200) begin @(negedge clk); n++; end
         check(last_gap_s == SLOT + 1, "R8 static slot gap", last_gap_s, SLOT + 1);
      end
      repeat (3) @(negedge clk);
      check(granted_s, "R8 static grant", granted_s, 1);
      @(negedge clk) rel_s = 1'b1;
      @(negedge clk) rel_s = 1'b0;
      check(!granted_s, "R7 static release", granted_s, 0);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (2000) @(negedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_uncontended();
      t_busy_poll();
      t_backoff();
      t_stall();
      t_static();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule